// File: doc/BRIEF.md
# Snooping MESI Cache-Line Controller

This block keeps the coherence state of a small direct-mapped copy-back cache whose lines are one data word wide. Several identical copies sit on one shared bus. On the core side, a request with an address, a write flag and write data is held until `cpu_ready`. Hits finish in the cycle they are presented. Misses and shared-line writes first win the bus through an outside arbiter.

The bus is a one-cycle transaction. The granted cache drives a command and an address, and every other cache sees the same pair on its snoop inputs. In that same cycle the snoopers answer with shared, supply, retry and copy-back flags and, where needed, their line data. A memory stub outside the block takes copy-back data and fills reads that no cache supplied. The command codes are READ=0, RWITM=1, INVAL=2 and WBACK=3. The line states are Invalid, Shared, Exclusive and Modified, held in 2 bits.

Top module: `mesi_line_ctrl`

## Requirements
- R1: After reset every line is invalid. The first access to any address misses and makes one bus transaction.
- R2: A read hit raises `cpu_ready` and `cpu_hit` in the cycle it is presented and returns the cached word. It makes no bus transaction and changes no state.
- R3: A read miss that no other cache answers takes memory data and installs the line Exclusive. A later write hit to that line then makes no bus transaction.
- R4: A read miss that hits an Exclusive or Shared copy elsewhere is served by that copy through the supply flag, and memory data is not used. Both copies become Shared, so a later write by either one broadcasts INVAL.
- R5: A read miss that hits a Modified copy elsewhere gets that copy's data. The holder raises copy-back so memory is updated, and both caches end Shared.
- R6: A write hit to a Modified or Exclusive line updates the data with no bus transaction and leaves the line Modified. Memory is not written.
- R7: A write hit to a Shared line first issues INVAL (code 2), then completes as a hit and the line becomes Modified. Other copies become Invalid, so their next read misses.
- R8: A write miss issues RWITM (code 1). Exclusive or Shared copies elsewhere become Invalid, and the requester installs the written word as Modified.
- R9: An RWITM that hits a Modified copy elsewhere is refused with retry. The holder copies back and becomes Invalid, and the requester reissues RWITM, which then completes from memory. This takes two grants.
- R10: A snoop changes or answers for a line only when the bus tag equals the stored tag of a valid line at that index. A WBACK (code 3) snoop never changes state or raises a response.
- R11: A miss whose victim line is Modified first issues WBACK carrying the victim address and data, and only then the fill. A clean victim is replaced with no extra transaction.
- R12: A snoop has priority. While the snoop input is active, the local request is held with `cpu_ready` low and the line is updated only by the snoop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_valid | input | 1 | Core request present, held until ready |
| cpu_write | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Request address (low IDX_W bits select the line) |
| cpu_wdata | input | DATA_W | Write data |
| cpu_ready | output | 1 | Request completes this cycle |
| cpu_hit | output | 1 | Completion was a hit |
| cpu_rdata | output | DATA_W | Read data |
| bus_req | output | 1 | Bus request |
| bus_gnt | input | 1 | Bus granted this cycle |
| bus_cmd | output | 2 | Command while requesting |
| bus_addr | output | ADDR_W | Transaction address |
| bus_wdata | output | DATA_W | Victim data for WBACK |
| bus_rsp_shared | input | 1 | Some other cache holds the line |
| bus_rsp_supply | input | 1 | Another cache supplies the data (memory cancelled) |
| bus_rsp_retry | input | 1 | Transaction refused, reissue |
| bus_rsp_data | input | DATA_W | Fill data, from a supplier or memory |
| snp_valid | input | 1 | Another cache owns the bus this cycle |
| snp_cmd | input | 2 | Snooped command |
| snp_addr | input | ADDR_W | Snooped address |
| snp_shared | output | 1 | This cache holds the snooped line |
| snp_supply | output | 1 | This cache supplies data for a READ |
| snp_retry | output | 1 | Refuse the RWITM |
| snp_wb | output | 1 | Copy-back request for snp_data |
| snp_data | output | DATA_W | Line data for supply or copy-back |

## Verification
Two instances share a bus and a memory stub. One fixed sequence drives a single index through every state pair: clean fill, silent upgrade, supply from Modified, invalidate from Shared, and the retried RWITM. Grant counts separate silent upgrades from broadcasts and one-pass fills from retried or victim-flushing ones. Returned data separates a supplied word from a stale memory word. Accesses that share an index but differ in tag show that snoops ignore unrelated lines. A final case has one cache write its Exclusive line while the other cache's read miss is being snooped. The supplied data, and the write that follows it, show the snoop taking priority.

// File: rtl/mesi_pkg.sv
package mesi_pkg;
   typedef enum logic [1:0] {
      ST_I = 2'd0,
      ST_S = 2'd1,
      ST_E = 2'd2,
      ST_M = 2'd3
   } mesi_t;

   typedef enum logic [1:0] {
      BC_READ  = 2'd0,
      BC_RWITM = 2'd1,
      BC_INVAL = 2'd2,
      BC_WBACK = 2'd3
   } bcmd_t;
endpackage

// File: rtl/mesi_line_array.sv
module mesi_line_array
   import mesi_pkg::*;
#(
   parameter int IDX_W  = 2,
   parameter int TAG_W  = 6,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IDX_W-1:0]  la_idx,
   output mesi_t             la_st,
   output logic [TAG_W-1:0]  la_tag,
   output logic [DATA_W-1:0] la_data,
   input  logic [IDX_W-1:0]  sa_idx,
   output mesi_t             sa_st,
   output logic [TAG_W-1:0]  sa_tag,
   output logic [DATA_W-1:0] sa_data,
   input  logic              sw_en,
   input  mesi_t             sw_st,
   input  logic              lw_en,
   input  mesi_t             lw_st,
   input  logic [TAG_W-1:0]  lw_tag,
   input  logic [DATA_W-1:0] lw_data
);
   localparam int LINES = 1 << IDX_W;

   mesi_t             st_q   [LINES];
   logic [TAG_W-1:0]  tag_q  [LINES];
   logic [DATA_W-1:0] data_q [LINES];

   always_ff @(posedge clk) begin
      for (int i = 0; i < LINES; i++) begin
         if (!rst_n) begin
            st_q[i]   <= ST_I;
            tag_q[i]  <= '0;
            data_q[i] <= '0;
         end else if (sw_en && sa_idx == IDX_W'(i)) begin
            st_q[i] <= sw_st;            // snoop wins the line
         end else if (lw_en && la_idx == IDX_W'(i)) begin
            st_q[i]   <= lw_st;
            tag_q[i]  <= lw_tag;
            data_q[i] <= lw_data;
         end
      end
   end

   assign la_st   = st_q[la_idx];
   assign la_tag  = tag_q[la_idx];
   assign la_data = data_q[la_idx];
   assign sa_st   = st_q[sa_idx];
   assign sa_tag  = tag_q[sa_idx];
   assign sa_data = data_q[sa_idx];
endmodule

// File: rtl/mesi_snoop_resp.sv
module mesi_snoop_resp
   import mesi_pkg::*;
#(
   parameter int TAG_W  = 6,
   parameter int DATA_W = 8
) (
   input  logic              snp_valid,
   input  bcmd_t             snp_cmd,
   input  logic [TAG_W-1:0]  snp_tag,
   input  mesi_t             ln_st,
   input  logic [TAG_W-1:0]  ln_tag,
   input  logic [DATA_W-1:0] ln_data,
   output logic              o_shared,
   output logic              o_supply,
   output logic              o_retry,
   output logic              o_wb,
   output logic [DATA_W-1:0] o_data,
   output logic              o_wr,
   output mesi_t             o_st
);
   logic match;
   assign match  = snp_valid && (ln_st != ST_I) && (ln_tag == snp_tag);
   assign o_data = ln_data;

   always_comb begin
      o_shared = 1'b0;
      o_supply = 1'b0;
      o_retry  = 1'b0;
      o_wb     = 1'b0;
      o_wr     = 1'b0;
      o_st     = ln_st;
      if (match) begin
         unique case (snp_cmd)
            BC_READ: begin
               o_shared = 1'b1;
               o_supply = 1'b1;
               o_wb     = (ln_st == ST_M);
               o_wr     = (ln_st != ST_S);
               o_st     = ST_S;
            end
            BC_RWITM: begin
               o_shared = 1'b1;
               o_retry  = (ln_st == ST_M);
               o_wb     = (ln_st == ST_M);
               o_wr     = 1'b1;
               o_st     = ST_I;
            end
            BC_INVAL: begin
               o_wr = 1'b1;
               o_st = ST_I;
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/mesi_req_fsm.sv
module mesi_req_fsm
   import mesi_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 8,
   parameter int IDX_W  = 2,
   parameter int TAG_W  = ADDR_W - IDX_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_valid,
   input  logic              cpu_write,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic              cpu_ready,
   output logic              cpu_hit,
   output logic [DATA_W-1:0] cpu_rdata,
   input  logic              snp_busy,
   input  mesi_t             ln_st,
   input  logic [TAG_W-1:0]  ln_tag,
   input  logic [DATA_W-1:0] ln_data,
   output logic              bus_req,
   input  logic              bus_gnt,
   output bcmd_t             bus_cmd,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_wdata,
   input  logic              rsp_shared,
   input  logic              rsp_supply,
   input  logic              rsp_retry,
   input  logic [DATA_W-1:0] rsp_data,
   output logic              lw_en,
   output mesi_t             lw_st,
   output logic [TAG_W-1:0]  lw_tag,
   output logic [DATA_W-1:0] lw_data
);
   typedef enum logic [1:0] {P_IDLE, P_WB, P_FILL, P_INV} phase_t;
   phase_t ps_q, ps_d;

   logic [TAG_W-1:0] rq_tag;
   logic [IDX_W-1:0] rq_idx;
   logic             hit;
   assign rq_tag = cpu_addr[ADDR_W-1:IDX_W];
   assign rq_idx = cpu_addr[IDX_W-1:0];
   assign hit    = (ln_st != ST_I) && (ln_tag == rq_tag);

   always_comb begin
      ps_d      = ps_q;
      cpu_ready = 1'b0;
      cpu_hit   = 1'b0;
      cpu_rdata = ln_data;
      bus_req   = 1'b0;
      bus_cmd   = BC_READ;
      bus_addr  = cpu_addr;
      bus_wdata = ln_data;
      lw_en     = 1'b0;
      lw_st     = ST_M;
      lw_tag    = rq_tag;
      lw_data   = cpu_wdata;
      unique case (ps_q)
         P_IDLE: if (cpu_valid && !snp_busy) begin
            if (hit && !cpu_write) begin
               cpu_ready = 1'b1;
               cpu_hit   = 1'b1;
            end else if (hit && ln_st == ST_S) begin
               ps_d = P_INV;
            end else if (hit) begin
               cpu_ready = 1'b1;
               cpu_hit   = 1'b1;
               lw_en     = 1'b1;
            end else begin
               ps_d = (ln_st == ST_M) ? P_WB : P_FILL;
            end
         end
         P_WB: begin
            if (ln_st != ST_M) begin
               ps_d = P_FILL;               // victim already flushed by a snoop
            end else begin
               bus_req  = 1'b1;
               bus_cmd  = BC_WBACK;
               bus_addr = {ln_tag, rq_idx};
               if (bus_gnt) begin
                  lw_en   = 1'b1;
                  lw_st   = ST_I;
                  lw_tag  = ln_tag;
                  lw_data = ln_data;
                  ps_d    = P_FILL;
               end
            end
         end
         P_FILL: begin
            bus_req = 1'b1;
            bus_cmd = cpu_write ? BC_RWITM : BC_READ;
            if (bus_gnt && !rsp_retry) begin
               cpu_ready = 1'b1;
               cpu_rdata = rsp_data;
               lw_en     = 1'b1;
               if (!cpu_write) begin
                  lw_st   = (rsp_shared || rsp_supply) ? ST_S : ST_E;
                  lw_data = rsp_data;
               end
               ps_d = P_IDLE;
            end
         end
         P_INV: begin
            if (!(hit && ln_st == ST_S)) begin
               ps_d = P_FILL;               // copy lost while waiting
            end else begin
               bus_req = 1'b1;
               bus_cmd = BC_INVAL;
               if (bus_gnt) begin
                  cpu_ready = 1'b1;
                  cpu_hit   = 1'b1;
                  lw_en     = 1'b1;
                  ps_d      = P_IDLE;
               end
            end
         end
         default: ps_d = P_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) ps_q <= P_IDLE;
      else        ps_q <= ps_d;
   end
endmodule

// File: rtl/mesi_line_ctrl.sv
module mesi_line_ctrl
   import mesi_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 8,
   parameter int IDX_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_valid,
   input  logic              cpu_write,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic              cpu_ready,
   output logic              cpu_hit,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic              bus_req,
   input  logic              bus_gnt,
   output logic [1:0]        bus_cmd,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_rsp_shared,
   input  logic              bus_rsp_supply,
   input  logic              bus_rsp_retry,
   input  logic [DATA_W-1:0] bus_rsp_data,
   input  logic              snp_valid,
   input  logic [1:0]        snp_cmd,
   input  logic [ADDR_W-1:0] snp_addr,
   output logic              snp_shared,
   output logic              snp_supply,
   output logic              snp_retry,
   output logic              snp_wb,
   output logic [DATA_W-1:0] snp_data
);
   localparam int TAG_W = ADDR_W - IDX_W;

   if (IDX_W < 1 || IDX_W >= ADDR_W) begin : g_bad_idx
      $error("IDX_W must lie in 1..ADDR_W-1");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("DATA_W must be positive");
   end

   mesi_t             la_st, sa_st, sw_st, lw_st;
   logic [TAG_W-1:0]  la_tag, sa_tag, lw_tag;
   logic [DATA_W-1:0] la_data, sa_data, lw_data;
   logic              sw_en, lw_en;
   bcmd_t             cmd_out;

   assign bus_cmd = cmd_out;

   mesi_line_array #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_lines (
      .clk(clk), .rst_n(rst_n),
      .la_idx(cpu_addr[IDX_W-1:0]), .la_st(la_st), .la_tag(la_tag), .la_data(la_data),
      .sa_idx(snp_addr[IDX_W-1:0]), .sa_st(sa_st), .sa_tag(sa_tag), .sa_data(sa_data),
      .sw_en(sw_en), .sw_st(sw_st),
      .lw_en(lw_en), .lw_st(lw_st), .lw_tag(lw_tag), .lw_data(lw_data)
   );

   mesi_snoop_resp #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_snoop (
      .snp_valid(snp_valid), .snp_cmd(bcmd_t'(snp_cmd)),
      .snp_tag(snp_addr[ADDR_W-1:IDX_W]),
      .ln_st(sa_st), .ln_tag(sa_tag), .ln_data(sa_data),
      .o_shared(snp_shared), .o_supply(snp_supply), .o_retry(snp_retry),
      .o_wb(snp_wb), .o_data(snp_data), .o_wr(sw_en), .o_st(sw_st)
   );

   mesi_req_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_req (
      .clk(clk), .rst_n(rst_n),
      .cpu_valid(cpu_valid), .cpu_write(cpu_write), .cpu_addr(cpu_addr),
      .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready), .cpu_hit(cpu_hit),
      .cpu_rdata(cpu_rdata), .snp_busy(snp_valid),
      .ln_st(la_st), .ln_tag(la_tag), .ln_data(la_data),
      .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_cmd(cmd_out),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .rsp_shared(bus_rsp_shared), .rsp_supply(bus_rsp_supply),
      .rsp_retry(bus_rsp_retry), .rsp_data(bus_rsp_data),
      .lw_en(lw_en), .lw_st(lw_st), .lw_tag(lw_tag), .lw_data(lw_data)
   );
endmodule

// File: rtl/mesi_line_ctrl_chk.sv
module mesi_line_ctrl_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       cpu_ready,
   input logic       cpu_hit,
   input logic       bus_req,
   input logic       bus_gnt,
   input logic [1:0] bus_cmd,
   input logic       bus_rsp_retry,
   input logic       snp_valid,
   input logic [1:0] snp_cmd,
   input logic       snp_supply,
   input logic       snp_retry,
   input logic       snp_wb
);
   a_r12_snoop_holds_local: assert property (@(posedge clk) disable iff (!rst_n)
      snp_valid |-> !cpu_ready);

   a_r2_hit_needs_no_bus: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_ready && cpu_hit && !bus_gnt) |-> !bus_req);

   a_r9_retry_only_rwitm: assert property (@(posedge clk) disable iff (!rst_n)
      snp_retry |-> (snp_valid && snp_cmd == 2'd1 && snp_wb));

   a_r9_reissue_after_retry: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_gnt && bus_cmd == 2'd1 && bus_rsp_retry) |=> (bus_req && bus_cmd == 2'd1));

   a_r5_read_copyback_supplies: assert property (@(posedge clk) disable iff (!rst_n)
      (snp_wb && snp_cmd == 2'd0) |-> snp_supply);

   a_r10_quiet_without_snoop: assert property (@(posedge clk) disable iff (!rst_n)
      !snp_valid |-> !(snp_supply || snp_retry || snp_wb));

   a_r10_wback_snoop_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (snp_valid && snp_cmd == 2'd3) |-> !(snp_supply || snp_retry || snp_wb));
endmodule

bind mesi_line_ctrl mesi_line_ctrl_chk u_chk (
   .clk(clk), .rst_n(rst_n), .cpu_ready(cpu_ready), .cpu_hit(cpu_hit),
   .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_cmd(bus_cmd),
   .bus_rsp_retry(bus_rsp_retry), .snp_valid(snp_valid), .snp_cmd(snp_cmd),
   .snp_supply(snp_supply), .snp_retry(snp_retry), .snp_wb(snp_wb)
);

// File: tb/mesi_line_ctrl_tb_top.sv
module mesi_line_ctrl_tb_top;
   localparam int CLK_P = 10;

   typedef struct packed {
      logic       c;     // cache 0 or 1
      logic       wr;
      logic [7:0] a;
      logic [7:0] d;
      logic       chkd;
      logic [7:0] exp;
      logic       eh;
      logic [3:0] eg;    // grants taken by this cache
      logic       chkm;
      logic [7:0] ma;
      logic [7:0] mv;
      logic [3:0] rq;
   } vec_t;

   localparam int NV = 24;
   localparam vec_t VT [NV] = '{
      '{1'b0,1'b0,8'h10,8'h00,1'b1,8'h4A,1'b0,4'd1,1'b1,8'h10,8'h4A,4'd1},  // R1 cold miss, E
      '{1'b0,1'b0,8'h10,8'h00,1'b1,8'h4A,1'b1,4'd0,1'b0,8'h00,8'h00,4'd2},  // R2
      '{1'b0,1'b1,8'h10,8'hA1,1'b0,8'h00,1'b1,4'd0,1'b1,8'h10,8'h4A,4'd3},  // R3 E->M silent
      '{1'b0,1'b1,8'h10,8'hA2,1'b0,8'h00,1'b1,4'd0,1'b1,8'h10,8'h4A,4'd6},  // R6
      '{1'b1,1'b0,8'h10,8'h00,1'b1,8'hA2,1'b0,4'd1,1'b1,8'h10,8'hA2,4'd5},  // R5 M supplies
      '{1'b0,1'b0,8'h10,8'h00,1'b1,8'hA2,1'b1,4'd0,1'b0,8'h00,8'h00,4'd5},
      '{1'b1,1'b1,8'h10,8'hB3,1'b0,8'h00,1'b1,4'd1,1'b0,8'h00,8'h00,4'd7},  // R7 INVAL
      '{1'b0,1'b0,8'h10,8'h00,1'b1,8'hB3,1'b0,4'd1,1'b1,8'h10,8'hB3,4'd7},
      '{1'b0,1'b1,8'h10,8'hC4,1'b0,8'h00,1'b1,4'd1,1'b0,8'h00,8'h00,4'd7},
      '{1'b1,1'b1,8'h10,8'hD5,1'b0,8'h00,1'b0,4'd2,1'b1,8'h10,8'hC4,4'd9},  // R9 retry
      '{1'b0,1'b0,8'h10,8'h00,1'b1,8'hD5,1'b0,4'd1,1'b1,8'h10,8'hD5,4'd9},
      '{1'b0,1'b0,8'h24,8'h00,1'b1,8'h7E,1'b0,4'd1,1'b0,8'h00,8'h00,4'd11}, // R11 clean victim
      '{1'b1,1'b0,8'h24,8'h00,1'b1,8'h7E,1'b0,4'd1,1'b1,8'h24,8'h7E,4'd4},  // R4 E supplies
      '{1'b0,1'b1,8'h24,8'h11,1'b0,8'h00,1'b1,4'd1,1'b0,8'h00,8'h00,4'd4},
      '{1'b1,1'b0,8'h24,8'h00,1'b1,8'h11,1'b0,4'd1,1'b1,8'h24,8'h11,4'd7},
      '{1'b0,1'b0,8'h31,8'h00,1'b1,8'h6B,1'b0,4'd1,1'b0,8'h00,8'h00,4'd3},
      '{1'b1,1'b1,8'h31,8'h22,1'b0,8'h00,1'b0,4'd1,1'b1,8'h31,8'h6B,4'd8},  // R8
      '{1'b0,1'b0,8'h31,8'h00,1'b1,8'h22,1'b0,4'd1,1'b1,8'h31,8'h22,4'd8},
      '{1'b0,1'b0,8'h02,8'h00,1'b1,8'h58,1'b0,4'd1,1'b0,8'h00,8'h00,4'd3},
      '{1'b1,1'b0,8'h42,8'h00,1'b1,8'h18,1'b0,4'd1,1'b0,8'h00,8'h00,4'd10}, // R10 tag differs
      '{1'b0,1'b1,8'h02,8'h33,1'b0,8'h00,1'b1,4'd0,1'b0,8'h00,8'h00,4'd10},
      '{1'b1,1'b1,8'h42,8'h44,1'b0,8'h00,1'b1,4'd0,1'b0,8'h00,8'h00,4'd10},
      '{1'b0,1'b0,8'h82,8'h00,1'b1,8'hD8,1'b0,4'd2,1'b1,8'h02,8'h33,4'd11}, // R11 dirty victim
      '{1'b1,1'b0,8'h42,8'h00,1'b1,8'h44,1'b1,4'd0,1'b0,8'h00,8'h00,4'd10}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #(CLK_P/2) clk = ~clk;

   logic       cv [2];
   logic       cw [2];
   logic [7:0] ca [2];
   logic [7:0] cd [2];
   logic       cr [2];
   logic       ch [2];
   logic [7:0] crd [2];
   logic       breq [2];
   logic       bg [2];
   logic [1:0] bcmd [2];
   logic [7:0] baddr [2];
   logic [7:0] bwd [2];
   logic       ssh [2];
   logic       ssup [2];
   logic       sret [2];
   logic       swb [2];
   logic [7:0] sdat [2];
   logic [7:0] rdat [2];
   logic [7:0] mem [256];
   int         gcnt [2];
   int         total = 0;
   int         bad = 0;

   assign bg[0] = breq[0];
   assign bg[1] = breq[1] && !breq[0];
   assign rdat[0] = ssup[1] ? sdat[1] : mem[baddr[0]];
   assign rdat[1] = ssup[0] ? sdat[0] : mem[baddr[1]];

   mesi_line_ctrl dut_i (
      .clk(clk), .rst_n(rst_n),
      .cpu_valid(cv[0]), .cpu_write(cw[0]), .cpu_addr(ca[0]), .cpu_wdata(cd[0]),
      .cpu_ready(cr[0]), .cpu_hit(ch[0]), .cpu_rdata(crd[0]),
      .bus_req(breq[0]), .bus_gnt(bg[0]), .bus_cmd(bcmd[0]), .bus_addr(baddr[0]),
      .bus_wdata(bwd[0]), .bus_rsp_shared(ssh[1]), .bus_rsp_supply(ssup[1]),
      .bus_rsp_retry(sret[1]), .bus_rsp_data(rdat[0]),
      .snp_valid(bg[1]), .snp_cmd(bcmd[1]), .snp_addr(baddr[1]),
      .snp_shared(ssh[0]), .snp_supply(ssup[0]), .snp_retry(sret[0]),
      .snp_wb(swb[0]), .snp_data(sdat[0])
   );

   mesi_line_ctrl peer_i (
      .clk(clk), .rst_n(rst_n),
      .cpu_valid(cv[1]), .cpu_write(cw[1]), .cpu_addr(ca[1]), .cpu_wdata(cd[1]),
      .cpu_ready(cr[1]), .cpu_hit(ch[1]), .cpu_rdata(crd[1]),
      .bus_req(breq[1]), .bus_gnt(bg[1]), .bus_cmd(bcmd[1]), .bus_addr(baddr[1]),
      .bus_wdata(bwd[1]), .bus_rsp_shared(ssh[0]), .bus_rsp_supply(ssup[0]),
      .bus_rsp_retry(sret[0]), .bus_rsp_data(rdat[1]),
      .snp_valid(bg[0]), .snp_cmd(bcmd[0]), .snp_addr(baddr[0]),
      .snp_shared(ssh[1]), .snp_supply(ssup[1]), .snp_retry(sret[1]),
      .snp_wb(swb[1]), .snp_data(sdat[1])
   );

   // memory stub: copy-backs and victim flushes land on the clock edge
   always @(posedge clk) begin
      for (int i = 0; i < 2; i++) begin
         if (bg[i]) begin
            gcnt[i] <= gcnt[i] + 1;
            if (bcmd[i] == 2'd3) mem[baddr[i]] <= bwd[i];
            if (swb[1-i])        mem[baddr[i]] <= sdat[1-i];
         end
      end
   end

   task automatic chk(input bit ok, input string rq, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
      end
   endtask

   task automatic cpu_op(input int c, input bit wr, input logic [7:0] a, input logic [7:0] d,
                         output logic [7:0] rd, output bit h, output int g);
      int g0;
      @(negedge clk);
      cv[c] = 1'b1; cw[c] = wr; ca[c] = a; cd[c] = d;
      g0 = gcnt[c];
      #1;
      while (!cr[c]) begin
         @(negedge clk);
         #1;
      end
      rd = crd[c];
      h  = ch[c];
      @(negedge clk);
      cv[c] = 1'b0;
      g = gcnt[c] - g0;
   endtask

   initial begin
      #(CLK_P * 150000);
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [7:0] rd, rd1;
      bit         h, h1;
      int         g, g1;
      for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'h5A;
      for (int i = 0; i < 2; i++) begin
         cv[i] = 1'b0; cw[i] = 1'b0; ca[i] = '0; cd[i] = '0; gcnt[i] = 0;
      end
      repeat (3) @(negedge clk);
      // R1: reset state at the ports
      chk(!cr[0] && !breq[0] && !swb[0] && !ssup[0], "R1 reset outputs", {cr[0], breq[0]}, 0);
      chk(!cr[1] && !breq[1] && !swb[1] && !ssup[1], "R1 reset outputs peer", {cr[1], breq[1]}, 0);
      rst_n = 1'b1;

      for (int k = 0; k < NV; k++) begin
         vec_t v;
         string tag;
         v = VT[k];
         tag = $sformatf("R%0d vec%0d", v.rq, k);
         cpu_op(int'(v.c), v.wr, v.a, v.d, rd, h, g);
         chk(h == v.eh, {tag, " hit"}, h, v.eh);
         chk(g == int'(v.eg), {tag, " grants"}, g, v.eg);
         if (v.chkd) chk(rd == v.exp, {tag, " data"}, rd, v.exp);
         if (v.chkm) chk(mem[v.ma] == v.mv, {tag, " memory"}, mem[v.ma], v.mv);
      end

      // R12: local write hit collides with a snoop of the peer's read miss
      cpu_op(0, 1'b0, 8'h13, 8'h00, rd, h, g);
      chk(rd == 8'h49 && g == 1, "R3 fill for R12 setup", rd, 8'h49);
      fork
         cpu_op(1, 1'b0, 8'h13, 8'h00, rd1, h1, g1);
         begin
            @(negedge clk);
            cpu_op(0, 1'b1, 8'h13, 8'h77, rd, h, g);
         end
         begin
            @(negedge clk);
            @(negedge clk);
            #2;
            chk(!cr[0] && bg[1], "R12 local held during snoop", cr[0], 0);
         end
      join
      chk(rd1 == 8'h49, "R12 peer got pre-write data", rd1, 8'h49);
      chk(h && g == 1, "R12 write became invalidate", g, 1);
      cpu_op(1, 1'b0, 8'h13, 8'h00, rd1, h1, g1);
      chk(rd1 == 8'h77 && !h1, "R12 write kept after snoop", rd1, 8'h77);

      // R1: reset again wipes every line
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      cpu_op(0, 1'b0, 8'h10, 8'h00, rd, h, g);
      chk(!h && g == 1 && rd == 8'hD5, "R1 miss after reset", rd, 8'hD5);
      cpu_op(1, 1'b0, 8'h42, 8'h00, rd, h, g);
      chk(!h && g == 1, "R1 peer miss after reset", g, 1);
      cpu_op(0, 1'b0, 8'h10, 8'h00, rd, h, g);
      chk(h && g == 0 && rd == 8'hD5, "R2 hit after refill", rd, 8'hD5);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule